// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a serial configuration port. A host selects it with an active-low select line, shifts in an instruction byte and then moves data bytes to or from one register of a small configuration bank. The instruction carries only a direction flag and a register address. The length of the data phase is not encoded in the instruction: it comes from a fixed width table that gives every register one to four bytes.

The serial pins are sampled by the block's own system clock through short synchronizers. The serial clock therefore acts as a data signal, and it must run well below the system clock. Register 0 holds the two port controls: one picks between a separate output pin and a single shared data pin, and the other picks the bit order. A select line raised in the middle of a cycle only pauses it. Eight serial clock rising edges seen while deselected return the port to the start of an instruction, which lets a host recover after losing alignment.

Top module: `spi_cfg_slave`

## Requirements
- R1: The instruction byte holds the direction in bit 7 (1 = read, 0 = write) and the register address in bits 4..0. Bits 6 and 5 have no effect.
- R2: Address a below 16 transfers (a mod 4) + 1 data bytes. Every address from 16 to 31 transfers exactly one byte.
- R3: A write changes the register only after its last data byte is received. A write cycle that is abandoned before that point leaves the register unchanged.
- R4: While csN is high, sdoOe and sdioOe are both 0. Raising csN in mid-cycle pauses the transfer. Fewer than eight sclk rising edges during the pause do not disturb it, and the cycle resumes at the next bit once csN is low again.
- R5: When register 0 bit 7 is 1 (three-wire), read data is driven on sdioOut with sdioOe = 1 and sdoOe = 0. When the bit is 0 (four-wire), read data is driven on sdoOut with sdoOe = 1 and sdioOe = 0. The two enables are never both 1.
- R6: When register 0 bit 6 is 0, every byte, including the instruction byte, is shifted most significant bit first. When the bit is 1, every byte is shifted least significant bit first.
- R7: In MSB-first order a multi-byte register moves from its top byte down to byte 0. In LSB-first order it moves from byte 0 up to its top byte.
- R8: Eight or more sclk rising edges while csN is high reset the port, so that the next selected bit is bit one of a new instruction.
- R9: After reset, every register reads 0, the port is in four-wire MSB-first mode and both output enables are 0.
- R10: Addresses 16 to 31 read as zero and ignore writes.
- R11: Input bits are taken at sclk rising edges. Read data changes after sclk falling edges. Several instructions may follow one another inside one select window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low select |
| sdioIn | input | 1 | Input side of the shared data pin |
| sdioOut | output | 1 | Read data for the shared pin in three-wire mode |
| sdioOe | output | 1 | Drive enable of the shared pin |
| sdoOut | output | 1 | Read data for the separate output pin |
| sdoOe | output | 1 | Drive enable of the separate output pin |

## Verification
The assertions assume that sclk, csN and sdioIn come from a host much slower than clk. Each sclk level must be held for more than the synchronizer depth plus one cycle. csN must change only while sclk is low, and data must be stable across every rising sclk edge. The bench keeps to these rules with eight-cycle half periods: it changes csN and sdioIn only in the low phase and waits a half period after every select change. Only the addresses, data, modes, junk instruction bits and pause points are drawn at random.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int ADDR_W    = 5;
  localparam int MAX_BYTES = 4;
  localparam int WORD_W    = 8 * MAX_BYTES;
  localparam int BPOS_W    = $clog2(MAX_BYTES);

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } spiPhase_t;

  // strobes from control to datapath, valid for one clk cycle
  typedef struct packed {
    logic              shift;    // take one serial bit
    logic              capture;  // store assembled write byte
    logic              commit;   // write staged word into the bank
    logic              launch;   // update the read output bit
    logic              clear;    // resync: drop partial state
    logic [BPOS_W-1:0] bytePos;  // byte lane of the current byte
    logic [2:0]        bitPos;   // bit within that byte
    logic [ADDR_W-1:0] addr;     // register of the current cycle
  } spiStrb_t;

  // number of data bytes of a register
  function automatic int regBytes(input logic [ADDR_W-1:0] a, input int numRegs);
    if (int'(a) < numRegs) return (int'(a) % MAX_BYTES) + 1;
    return 1;
  endfunction

endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int RESYNC_EDGES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csHigh,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              lsbFirst,
  input  logic              instrRw,
  input  logic [ADDR_W-1:0] instrAddr,
  output spiStrb_t          strb,
  output logic              inData,
  output logic              isRead,
  output logic [2:0]        bitCnt
);

  localparam int IDLE_W = $clog2(RESYNC_EDGES + 1);

  spiPhase_t         phase;
  logic [IDLE_W-1:0] idleCnt;
  logic [BPOS_W-1:0] byteIdx;
  logic [BPOS_W-1:0] lastIdx;
  logic [ADDR_W-1:0] addrQ;
  logic              rwQ;
  logic              rxEdge;
  logic              byteEnd;
  logic              lastByte;
  logic              instrEnd;
  logic              dataEnd;

  always_comb begin
    rxEdge   = !csHigh && sclkRise;
    byteEnd  = rxEdge && (bitCnt == 3'd7);
    lastByte = (byteIdx == lastIdx);
    instrEnd = byteEnd && (phase == PH_INSTR);
    dataEnd  = byteEnd && (phase == PH_DATA);

    strb         = '0;
    strb.shift   = rxEdge;
    strb.capture = dataEnd && !rwQ;
    strb.commit  = dataEnd && !rwQ && lastByte;
    strb.launch  = !csHigh && sclkFall && (phase == PH_DATA) && rwQ;
    strb.clear   = csHigh && sclkRise && (int'(idleCnt) >= RESYNC_EDGES - 1);
    strb.bytePos = lsbFirst ? byteIdx : (lastIdx - byteIdx);
    strb.bitPos  = lsbFirst ? bitCnt : (3'd7 - bitCnt);
    strb.addr    = addrQ;
  end

  // count serial clock edges seen while deselected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (!csHigh) begin
      idleCnt <= '0;
    end else if (sclkRise && (int'(idleCnt) < RESYNC_EDGES)) begin
      idleCnt <= idleCnt + IDLE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_INSTR;
      bitCnt  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      addrQ   <= '0;
      rwQ     <= 1'b0;
    end else if (strb.clear) begin
      phase   <= PH_INSTR;
      bitCnt  <= '0;
      byteIdx <= '0;
    end else if (rxEdge) begin
      bitCnt <= bitCnt + 3'd1;
      if (instrEnd) begin
        rwQ     <= instrRw;
        addrQ   <= instrAddr;
        lastIdx <= BPOS_W'(regBytes(instrAddr, NUM_REGS) - 1);
        byteIdx <= '0;
        phase   <= PH_DATA;
      end else if (dataEnd) begin
        if (lastByte) phase <= PH_INSTR;
        else          byteIdx <= byteIdx + BPOS_W'(1);
      end
    end
  end

  assign inData = (phase == PH_DATA);
  assign isRead = rwQ;

endmodule

// File: rtl/spi_cfg_datapath.sv
module spi_cfg_datapath
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdiBit,
  input  spiStrb_t          strb,
  output logic              instrRw,
  output logic [ADDR_W-1:0] instrAddr,
  output logic              txBit,
  output logic              lsbFirst,
  output logic              threeWire
);

  logic [7:0]                         shiftQ;
  logic [7:0]                         rxByte;
  logic [WORD_W-1:0]                  wrBuf;
  logic [WORD_W-1:0]                  merged;
  logic [WORD_W-1:0]                  rdWord;
  logic [NUM_REGS-1:0][WORD_W-1:0]    regFlat;

  // byte as it stands once the current bit is included
  always_comb begin
    rxByte = lsbFirst ? {sdiBit, shiftQ[7:1]} : {shiftQ[6:0], sdiBit};
  end

  always_comb begin
    merged = wrBuf;
    merged[8*strb.bytePos +: 8] = rxByte;
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strb.addr == ADDR_W'(i)) rdWord = regFlat[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      wrBuf  <= '0;
      txBit  <= 1'b0;
    end else begin
      if (strb.clear)        shiftQ <= '0;
      else if (strb.shift)   shiftQ <= rxByte;
      if (strb.clear)        wrBuf  <= '0;
      else if (strb.capture) wrBuf  <= merged;
      if (strb.launch)       txBit  <= rdWord[{strb.bytePos, strb.bitPos}];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam int NB = regBytes(ADDR_W'(g), NUM_REGS);
    localparam logic [WORD_W-1:0] MASK = WORD_W'((64'd1 << (8 * NB)) - 64'd1);
    logic [WORD_W-1:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val <= '0;
      end else if (strb.commit && (strb.addr == ADDR_W'(g))) begin
        val <= merged & MASK;
      end
    end
    assign regFlat[g] = val;
  end

  assign instrRw   = rxByte[7];
  assign instrAddr = rxByte[ADDR_W-1:0];
  assign threeWire = regFlat[0][7];
  assign lsbFirst  = regFlat[0][6];

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS     = 16,
  parameter int RESYNC_EDGES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic sdioIn,
  output logic sdioOut,
  output logic sdioOe,
  output logic sdoOut,
  output logic sdoOe
);

  logic [SYNC_STAGES-1:0] sclkPipe;
  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] sdiPipe;
  logic                   sclkLast;
  logic                   sclkSync;
  logic                   csNSync;
  logic                   sdiSync;
  logic                   sclkRise;
  logic                   sclkFall;
  spiStrb_t               strb;
  logic                   inData;
  logic                   isRead;
  logic [2:0]             bitCnt;
  logic                   instrRw;
  logic [ADDR_W-1:0]      instrAddr;
  logic                   txBit;
  logic                   lsbFirst;
  logic                   threeWire;
  logic                   readDrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdiPipe  <= '0;
      sclkLast <= 1'b0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csN};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdioIn};
      sclkLast <= sclkSync;
    end
  end

  assign sclkSync = sclkPipe[SYNC_STAGES-1];
  assign csNSync  = csPipe[SYNC_STAGES-1];
  assign sdiSync  = sdiPipe[SYNC_STAGES-1];
  assign sclkRise = sclkSync && !sclkLast;
  assign sclkFall = !sclkSync && sclkLast;

  spi_cfg_ctrl #(
    .NUM_REGS    (NUM_REGS),
    .RESYNC_EDGES(RESYNC_EDGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csHigh   (csNSync),
    .sclkRise (sclkRise),
    .sclkFall (sclkFall),
    .lsbFirst (lsbFirst),
    .instrRw  (instrRw),
    .instrAddr(instrAddr),
    .strb     (strb),
    .inData   (inData),
    .isRead   (isRead),
    .bitCnt   (bitCnt)
  );

  spi_cfg_datapath #(
    .NUM_REGS(NUM_REGS)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sdiBit   (sdiSync),
    .strb     (strb),
    .instrRw  (instrRw),
    .instrAddr(instrAddr),
    .txBit    (txBit),
    .lsbFirst (lsbFirst),
    .threeWire(threeWire)
  );

  assign readDrive = !csNSync && inData && isRead;
  assign sdoOe     = readDrive && !threeWire;
  assign sdioOe    = readDrive && threeWire;
  assign sdoOut    = txBit;
  assign sdioOut   = txBit;

endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker
  import spi_cfg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       csNSync,
  input logic       sdoOe,
  input logic       sdioOe,
  input logic       threeWire,
  input spiStrb_t   strb,
  input logic       inData,
  input logic [2:0] bitCnt
);

  // R4: a select held high for the synchronizer depth releases both pins
  p_hiz_deselected_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> (!sdoOe && !sdioOe));

  // R4: a paused cycle keeps its position unless a resync fires
  p_pause_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csNSync && !strb.clear) |=> ($stable(bitCnt) && $stable(inData)));

  // R5: never two drivers
  p_single_pin_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(sdoOe && sdioOe));

  // R5: the separate output stays released in three-wire mode
  p_sdo_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    threeWire |-> !sdoOe);

  // R8: resync lands at the first bit of an instruction
  p_resync_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!inData && bitCnt == 3'd0));

endmodule

bind spi_cfg_slave spi_cfg_checker i_spi_cfg_checker (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .csNSync  (csNSync),
  .sdoOe    (sdoOe),
  .sdioOe   (sdioOe),
  .threeWire(threeWire),
  .strb     (strb),
  .inData   (inData),
  .bitCnt   (bitCnt)
);

// File: tb/test_spi_cfg_slave.sv
`timescale 1ns/1ps
module test_spi_cfg_slave;

  localparam int HALF = 8;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] mdl [32];
  logic lsbM = 1'b0;
  logic threeM = 1'b0;
  int bitNo = 0;
  int suspendAt = -1;
  int suspendEdges = 0;
  int unsigned seedSet;

  spi_cfg_slave #(.NUM_REGS(NREG)) i_spi_cfg_slave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  always #2 clk = ~clk;

  function automatic int bW(input int a);
    return (a < NREG) ? (a % 4) + 1 : 1;
  endfunction

  function automatic logic [31:0] bMask(input int a);
    if (a >= NREG) return 32'h0;
    if (bW(a) == 4) return 32'hFFFF_FFFF;
    return (32'd1 << (8 * bW(a))) - 32'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; idle(HALF);
    sclk = 1'b0; idle(HALF);
  endtask

  task automatic suspendNow();
    idle(HALF);
    csN = 1'b1; idle(HALF);
    chk(!sdoOe && !sdioOe, "R4 pins released while paused", {30'd0, sdoOe, sdioOe}, 32'd0);
    repeat (suspendEdges) pulse();
    csN = 1'b0; idle(HALF);
  endtask

  task automatic bitXfer(input logic din, output logic rx, output logic pinOk);
    if (bitNo == suspendAt) suspendNow();
    bitNo++;
    sdioIn = din;
    idle(HALF);
    rx = threeM ? sdioOut : sdoOut;
    pinOk = threeM ? (sdioOe && !sdoOe) : (sdoOe && !sdioOe);
    sclk = 1'b1; idle(HALF);
    sclk = 1'b0;
  endtask

  task automatic xfer(input bit rd, input int addr, input logic [1:0] junk, input logic [31:0] wd,
                      output logic [31:0] rdv, output bit pinsOk);
    logic [7:0] ins;
    logic rx, ok;
    int n;
    ins = {rd, junk, addr[4:0]};
    n = bW(addr);
    rdv = '0;
    pinsOk = 1'b1;
    bitNo = 0;
    for (int b = 0; b < 8; b++) bitXfer(ins[lsbM ? b : 7 - b], rx, ok);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = lsbM ? k : n - 1 - k;
      for (int b = 0; b < 8; b++) begin
        int pos;
        pos = lsbM ? b : 7 - b;
        bitXfer(wd[idx*8 + pos], rx, ok);
        if (rd) begin
          rdv[idx*8 + pos] = rx;
          if (!ok) pinsOk = 1'b0;
        end
      end
    end
    if (!rd && addr < NREG) begin
      mdl[addr] = wd & bMask(addr);
      if (addr == 0) begin
        lsbM = wd[6];
        threeM = wd[7];
      end
    end
    suspendAt = -1;
  endtask

  task automatic wr(input int addr, input logic [31:0] wd, input logic [1:0] junk);
    logic [31:0] dummy;
    bit pk;
    csN = 1'b0; idle(4);
    xfer(1'b0, addr, junk, wd, dummy, pk);
    idle(4); csN = 1'b1; idle(HALF);
  endtask

  task automatic rdChk(input int addr, input string req);
    logic [31:0] v;
    bit pk;
    csN = 1'b0; idle(4);
    xfer(1'b1, addr, 2'($urandom), 32'h0, v, pk);
    idle(4); csN = 1'b1; idle(HALF);
    chk(v == mdl[addr], req, v, mdl[addr]);
    chk(pk, {req, " R5 pin choice"}, {31'd0, pk}, 32'd1);
  endtask

  initial begin
    logic rx, ok;
    logic [31:0] v;
    bit pk;
    int a;
    logic [31:0] d;
    seedSet = $urandom(32'd20240611);
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    idle(5);
    rstN = 1'b1;
    idle(5);

    // R9: reset state
    chk(!sdoOe && !sdioOe, "R9 enables after reset", {30'd0, sdoOe, sdioOe}, 32'd0);
    rdChk(0, "R9 control register reset");
    rdChk(3, "R9 data register reset");

    // R1 R2 R7: MSB-first four-wire, junk bits set in the instruction
    wr(3, 32'hA1B2_C3D4, 2'b11);
    rdChk(3, "R1 R7 four-byte readback MSB-first");
    wr(1, 32'hFFFF_1234, 2'b10);
    rdChk(1, "R2 two-byte register keeps two bytes");
    wr(2, 32'h0055_AA33, 2'b01);
    rdChk(2, "R2 three-byte register");

    // R10: unimplemented address
    wr(20, 32'h0000_00FF, 2'b00);
    rdChk(20, "R10 unimplemented reads zero");
    rdChk(3, "R2 R10 one-byte slot kept alignment");

    // R6 R7: LSB-first
    wr(0, 32'h0000_0040, 2'b00);
    wr(3, 32'h0BAD_F00D, 2'b11);
    rdChk(3, "R6 R7 four-byte readback LSB-first");
    rdChk(0, "R6 control readback LSB-first");

    // R5: three-wire in both orders
    wr(0, 32'h0000_00C0, 2'b00);
    rdChk(3, "R5 three-wire LSB-first read");
    wr(0, 32'h0000_0080, 2'b00);
    rdChk(2, "R5 three-wire MSB-first read");
    wr(0, 32'h0000_0000, 2'b00);

    // R4: pause mid-byte with idle edges, on a write and on a read
    suspendAt = 13; suspendEdges = 5;
    wr(7, 32'h1357_9BDF, 2'b00);
    suspendAt = 20; suspendEdges = 0;
    rdChk(7, "R4 paused write and read resume");

    // R3 R8: abandoned write then resync
    wr(2, 32'h005A_C37E, 2'b00);
    csN = 1'b0; idle(4);
    bitNo = 0;
    for (int b = 0; b < 8; b++) bitXfer(8'h02 >> (7 - b), rx, ok);
    for (int b = 0; b < 16; b++) bitXfer(1'b1, rx, ok);
    idle(HALF); csN = 1'b1; idle(HALF);
    repeat (8) pulse();
    rdChk(2, "R3 R8 abandoned write leaves register");

    // R8: misaligned instruction then resync
    csN = 1'b0; idle(4);
    bitNo = 0;
    for (int b = 0; b < 3; b++) bitXfer(1'b1, rx, ok);
    idle(HALF); csN = 1'b1; idle(HALF);
    repeat (9) pulse();
    rdChk(3, "R8 resync after partial instruction");

    // R11 R1 R6 R5: random write-then-read pairs in one select window
    for (int it = 0; it < 40; it++) begin
      a = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 31));
      d = $urandom;
      csN = 1'b0; idle(4);
      xfer(1'b0, a, 2'($urandom), d, v, pk);
      xfer(1'b1, a, 2'($urandom), 32'h0, v, pk);
      idle(4); csN = 1'b1; idle(HALF);
      chk(v == mdl[a], "R11 back-to-back write and read", v, mdl[a]);
      chk(pk, "R11 R5 read pins", {31'd0, pk}, 32'd1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule